// File: doc/BRIEF.md
# Boost PFC Input-Current Regulator Datapath

This block is the inner current loop of a boost power-factor-correction stage. It runs once per control period, on a start strobe. From three values produced elsewhere (the outer voltage-regulator output, a rectified-sine phase weight and a filtered input-voltage magnitude) it forms a current reference that tracks the line voltage shape. It turns a raw 12-bit current-sense code into a signed current. The sense path inverts, so the code is mirrored, scaled by eight and corrected by a stored offset. A PI regulator with a clamped integrator acts on the difference between the reference and the measured current.

A duty feed-forward term is added to the PI result. It is taken from the DC-link voltage target and the input voltage, and the sum is clamped into the PWM compare range. Both divisions share one restoring divider that produces one quotient bit per clock. Every update therefore takes the same number of cycles, far fewer than a 40 kHz control period. The done strobe marks the clock in which the new compare value appears.

Top module: `pfc_iloop`

## Requirements
- R1: While `rst_n` is low, `pwm` is 0 and `done` is 0. The integrator is zero, so the first update after reset starts from an empty integral.
- R2: The current reference is floor(floor(`v_loop` × `sine_ph` / (`vin_mag` + 1)) / 2^17). All operands are unsigned, and `sine_ph` = 16384 means unity.
- R3: The measured current is ((4095 − `adc_raw`) × 8) − `i_ofs`, where `i_ofs` is a two's-complement offset.
- R4: On each update the integrator gains error × `ki`, where error = reference − measured current. The PI sum uses the updated integrator value.
- R5: After each addition the integrator is clamped to the signed range [`integ_lo`, `integ_hi`].
- R6: The PI output is floor((error × `kp` + integrator) / 2^16), rounding toward minus infinity.
- R7: The feed-forward term is d = `vlink_ref` − floor(`vin_mag` / 64). Its value is sign(d) × floor(|d| × `pwm_max` / `vlink_ref`), and it is 0 when `vlink_ref` is 0.
- R8: `pwm` takes PI output + feed-forward, clamped to the range 0 to `pwm_max`.
- R9: `done` is high for exactly one clock, after the 70th rising edge, counting as edge 1 the edge that samples `start` while idle. `pwm` changes on that same edge and holds at every other edge.
- R10: A `start` pulse that arrives while an update is running is ignored. It neither restarts nor delays that update.
- R11: `v_loop`, `sine_ph`, `vin_mag`, `adc_raw`, `i_ofs` and `vlink_ref` are sampled on the start edge. Changes to them later in the update have no effect. `kp`, `ki`, the integrator limits and `pwm_max` must be held steady for the whole update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins one update when idle |
| v_loop | input | 16 | Outer voltage-regulator output (unsigned) |
| sine_ph | input | 15 | Rectified-sine phase weight, 16384 = unity |
| vin_mag | input | 16 | Filtered input-voltage magnitude |
| adc_raw | input | 12 | Raw current-sense ADC code (inverted sense) |
| i_ofs | input | 16 | Signed current-sense offset |
| kp | input | 16 | Proportional gain (unsigned) |
| ki | input | 16 | Integral gain (unsigned) |
| integ_lo | input | 40 | Signed lower integrator limit |
| integ_hi | input | 40 | Signed upper integrator limit |
| vlink_ref | input | 16 | DC-link voltage target |
| pwm_max | input | 16 | Largest PWM compare count |
| done | output | 1 | One-cycle strobe when `pwm` is updated |
| pwm | output | 16 | PWM compare value |

## Verification
A bad divider step or a misrouted operand shows up in the very next update. The `pwm` result is then wrong, or `done` lands on a cycle other than the 70th. Integrator damage is different: a wrong accumulation, a wrong clamp or a missed reset can stay hidden in one result. It only becomes visible over several updates, as the reference model's integral and the design's drift apart and the compare values diverge. A duty sequence that runs through unclamped, clamped-high and clamped-low outcomes, with both integrator limits reached, exposes such drift within two to three updates.

// File: rtl/pfc_iloop_pkg.sv
package pfc_iloop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1,
    ST_W1,
    ST_L2,
    ST_W2,
    ST_PI
  } pfc_st_e;
endpackage

// File: rtl/pfc_seq_div.sv
// Restoring unsigned divider, one quotient bit per clock; fin pulses NW clocks after go.
module pfc_seq_div #(
  parameter int NW = 32,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic          fin
);
  localparam int CW = $clog2(NW + 1);

  logic [DW:0]   rem_q, rem_d, rem_sh;
  logic [NW-1:0] quo_q, quo_d;
  logic [DW-1:0] den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fin_q, fin_d, step_en;

  assign step_en = go || (cnt_q != '0);
  assign rem_sh  = {rem_q[DW-1:0], quo_q[NW-1]};

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    den_d = den_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = CW'(NW);
    end else if (cnt_q != '0) begin
      if (rem_sh >= {1'b0, den_q}) begin
        rem_d = rem_sh - {1'b0, den_q};
        quo_d = {quo_q[NW-2:0], 1'b1};
      end else begin
        rem_d = rem_sh;
        quo_d = {quo_q[NW-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      fin_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= fin_d;
      if (step_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        den_q <= den_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign quo = quo_q;
  assign fin = fin_q;
endmodule

// File: rtl/pfc_sense_conv.sv
// Mirrors the inverted sense code, scales it and removes the offset.
module pfc_sense_conv #(
  parameter int ADC_W = 12,
  parameter int OFS_W = 16,
  parameter int SH    = 3,
  parameter int MW    = 18
) (
  input  logic [ADC_W-1:0]        adc,
  input  logic signed [OFS_W-1:0] ofs,
  output logic signed [MW-1:0]    meas
);
  logic signed [MW-1:0] mirror_x;
  assign mirror_x = $signed(MW'({~adc, {SH{1'b0}}}));
  assign meas     = mirror_x - MW'(ofs);
endmodule

// File: rtl/pfc_pi_stage.sv
// Error, clamped integrator, PI shift, feed-forward sum and output clamp.
module pfc_pi_stage #(
  parameter int IRW   = 15,
  parameter int MW    = 18,
  parameter int GW    = 16,
  parameter int ACC_W = 40,
  parameter int FFW   = 33,
  parameter int PW    = 16,
  parameter int PI_SH = 16
) (
  input  logic [IRW-1:0]          iref,
  input  logic signed [MW-1:0]    meas,
  input  logic signed [ACC_W-1:0] integ_q,
  input  logic [GW-1:0]           kp,
  input  logic [GW-1:0]           ki,
  input  logic signed [ACC_W-1:0] lo,
  input  logic signed [ACC_W-1:0] hi,
  input  logic signed [FFW-1:0]   ff,
  input  logic [PW-1:0]           pmax,
  output logic signed [ACC_W-1:0] integ_d,
  output logic [PW-1:0]           pwm_d
);
  localparam int EW  = ((IRW > MW) ? IRW : MW) + 2;
  localparam int PRW = EW + GW + 1;
  localparam int M1  = (ACC_W > PRW) ? ACC_W : PRW;
  localparam int SW  = ((M1 > FFW) ? M1 : FFW) + 3;

  logic signed [SW-1:0] err, kp_x, ki_x, pki, pkp, isum, psum, tot;
  logic signed [SW-1:0] hi_x, lo_x, pmax_x;

  always_comb begin
    err    = $signed(SW'(iref)) - SW'(meas);
    kp_x   = $signed(SW'(kp));
    ki_x   = $signed(SW'(ki));
    pki    = err * ki_x;
    pkp    = err * kp_x;
    hi_x   = SW'(hi);
    lo_x   = SW'(lo);
    isum   = SW'(integ_q) + pki;
    if (isum > hi_x)      integ_d = hi;
    else if (isum < lo_x) integ_d = lo;
    else                  integ_d = isum[ACC_W-1:0];
    psum   = pkp + SW'(integ_d);
    tot    = (psum >>> PI_SH) + SW'(ff);
    pmax_x = $signed(SW'(pmax));
    if (tot[SW-1])        pwm_d = '0;
    else if (tot > pmax_x) pwm_d = pmax;
    else                  pwm_d = tot[PW-1:0];
  end
endmodule

// File: rtl/pfc_iloop.sv
module pfc_iloop
  import pfc_iloop_pkg::*;
#(
  parameter int ADC_W   = 12,
  parameter int VW      = 16,
  parameter int SINE_W  = 15,
  parameter int ACC_W   = 40,
  parameter int REF_SH  = 17,
  parameter int PI_SH   = 16,
  parameter int VIN_SH  = 6,
  parameter int ADC_SH  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [VW-1:0]           v_loop,
  input  logic [SINE_W-1:0]       sine_ph,
  input  logic [VW-1:0]           vin_mag,
  input  logic [ADC_W-1:0]        adc_raw,
  input  logic signed [VW-1:0]    i_ofs,
  input  logic [VW-1:0]           kp,
  input  logic [VW-1:0]           ki,
  input  logic signed [ACC_W-1:0] integ_lo,
  input  logic signed [ACC_W-1:0] integ_hi,
  input  logic [VW-1:0]           vlink_ref,
  input  logic [VW-1:0]           pwm_max,
  output logic                    done,
  output logic [VW-1:0]           pwm
);
  localparam int NW  = (VW + SINE_W > 2 * VW) ? VW + SINE_W : 2 * VW;
  localparam int DW  = VW + 1;
  localparam int IRW = NW - REF_SH;
  localparam int MW  = ((ADC_W + ADC_SH > VW) ? ADC_W + ADC_SH : VW) + 2;
  localparam int FFW = NW + 1;

  pfc_st_e st_q, st_d;
  logic [NW-1:0]           num1_q, num2_q, num1_w, num2_w, div_num, div_q;
  logic [DW-1:0]           den1_q, den1_w, div_den;
  logic [VW-1:0]           vlink_q, mag_w;
  logic                    ffneg_q, div_go, div_fin, done_q, busy_w;
  logic signed [VW:0]      diff_w, neg_w;
  logic signed [MW-1:0]    meas_q, meas_w;
  logic [IRW-1:0]          iref_q;
  logic signed [FFW-1:0]   ff_q, ff_w, qx_w;
  logic signed [ACC_W-1:0] integ_q, integ_w;
  logic [VW-1:0]           pwm_q, pwm_w;
  logic                    cap_en, ref_en, ff_en, upd_en;

  assign busy_w = (st_q != ST_IDLE);
  assign cap_en = start && !busy_w;
  assign ref_en = (st_q == ST_W1) && div_fin;
  assign ff_en  = (st_q == ST_W2) && div_fin;
  assign upd_en = (st_q == ST_PI);

  // Operand preparation on the start edge
  assign num1_w = {{(NW-VW){1'b0}}, v_loop} * {{(NW-SINE_W){1'b0}}, sine_ph};
  assign den1_w = {1'b0, vin_mag} + DW'(1);
  assign diff_w = $signed({1'b0, vlink_ref}) - $signed({1'b0, (vin_mag >> VIN_SH)});
  assign neg_w  = -diff_w;
  assign mag_w  = diff_w[VW] ? neg_w[VW-1:0] : diff_w[VW-1:0];
  assign num2_w = {{(NW-VW){1'b0}}, mag_w} * {{(NW-VW){1'b0}}, pwm_max};

  pfc_sense_conv #(.ADC_W(ADC_W), .OFS_W(VW), .SH(ADC_SH), .MW(MW)) u_sense (
    .adc (adc_raw),
    .ofs (i_ofs),
    .meas(meas_w)
  );

  // Shared divider: reference quotient first, feed-forward quotient second
  assign div_go  = (st_q == ST_L1) || (st_q == ST_L2);
  assign div_num = (st_q == ST_L1) ? num1_q : num2_q;
  assign div_den = (st_q == ST_L1) ? den1_q : {1'b0, vlink_q};

  pfc_seq_div #(.NW(NW), .DW(DW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .quo  (div_q),
    .fin  (div_fin)
  );

  assign qx_w = $signed({1'b0, div_q});
  assign ff_w = (vlink_q == '0) ? '0 : (ffneg_q ? -qx_w : qx_w);

  pfc_pi_stage #(
    .IRW(IRW), .MW(MW), .GW(VW), .ACC_W(ACC_W),
    .FFW(FFW), .PW(VW), .PI_SH(PI_SH)
  ) u_pi (
    .iref   (iref_q),
    .meas   (meas_q),
    .integ_q(integ_q),
    .kp     (kp),
    .ki     (ki),
    .lo     (integ_lo),
    .hi     (integ_hi),
    .ff     (ff_q),
    .pmax   (pwm_max),
    .integ_d(integ_w),
    .pwm_d  (pwm_w)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start)   st_d = ST_L1;
      ST_L1:                st_d = ST_W1;
      ST_W1:   if (div_fin) st_d = ST_L2;
      ST_L2:                st_d = ST_W2;
      ST_W2:   if (div_fin) st_d = ST_PI;
      ST_PI:                st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      num1_q  <= '0;
      num2_q  <= '0;
      den1_q  <= '0;
      vlink_q <= '0;
      ffneg_q <= 1'b0;
      meas_q  <= '0;
      iref_q  <= '0;
      ff_q    <= '0;
      integ_q <= '0;
      pwm_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= upd_en;
      if (cap_en) begin
        num1_q  <= num1_w;
        num2_q  <= num2_w;
        den1_q  <= den1_w;
        vlink_q <= vlink_ref;
        ffneg_q <= diff_w[VW];
        meas_q  <= meas_w;
      end
      if (ref_en) iref_q <= div_q[NW-1:REF_SH];
      if (ff_en)  ff_q   <= ff_w;
      if (upd_en) begin
        integ_q <= integ_w;
        pwm_q   <= pwm_w;
      end
    end
  end

  assign done = done_q;
  assign pwm  = pwm_q;
endmodule

// File: rtl/pfc_iloop_chk.sv
module pfc_iloop_chk #(
  parameter int PW    = 16,
  parameter int ACC_W = 40
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    done,
  input logic                    busy,
  input logic [PW-1:0]           pwm,
  input logic [PW-1:0]           pwm_max,
  input logic signed [ACC_W-1:0] integ,
  input logic signed [ACC_W-1:0] lo,
  input logic signed [ACC_W-1:0] hi
);
  // R8
  pwm_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pwm <= pwm_max));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pwm));

  // R9
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R5
  integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((integ >= lo) && (integ <= hi)));
endmodule

bind pfc_iloop pfc_iloop_chk #(.PW(VW), .ACC_W(ACC_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .done   (done),
  .busy   (busy_w),
  .pwm    (pwm),
  .pwm_max(pwm_max),
  .integ  (integ_q),
  .lo     (integ_lo),
  .hi     (integ_hi)
);

// File: tb/pfc_iloop_tb.sv
module pfc_iloop_tb;
  localparam int LAT = 70;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic [15:0]        v_loop;
  logic [14:0]        sine_ph;
  logic [15:0]        vin_mag;
  logic [11:0]        adc_raw;
  logic signed [15:0] i_ofs;
  logic [15:0]        kp, ki;
  logic signed [39:0] integ_lo, integ_hi;
  logic [15:0]        vlink_ref, pwm_max;
  logic               done;
  logic [15:0]        pwm;

  int     n_chk = 0;
  int     n_err = 0;
  longint integ_m = 0;
  longint pwm_m = 0;

  always #10 clk = ~clk;

  pfc_iloop u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .v_loop(v_loop), .sine_ph(sine_ph),
    .vin_mag(vin_mag), .adc_raw(adc_raw), .i_ofs(i_ofs), .kp(kp), .ki(ki),
    .integ_lo(integ_lo), .integ_hi(integ_hi), .vlink_ref(vlink_ref),
    .pwm_max(pwm_max), .done(done), .pwm(pwm)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference of one update
  task automatic model(output longint np, output longint ni);
    longint iref, meas, err, isum, pi, d, m, ff, tot;
    iref = ((longint'(v_loop) * longint'(sine_ph)) / (longint'(vin_mag) + 1)) >>> 17;
    meas = ((4095 - longint'(adc_raw)) * 8) - longint'(i_ofs);
    err  = iref - meas;
    isum = integ_m + err * longint'(ki);
    if (isum > longint'(integ_hi)) ni = longint'(integ_hi);
    else if (isum < longint'(integ_lo)) ni = longint'(integ_lo);
    else ni = isum;
    pi = (err * longint'(kp) + ni) >>> 16;
    if (vlink_ref == 16'd0) ff = 0;
    else begin
      d  = longint'(vlink_ref) - (longint'(vin_mag) >> 6);
      m  = ((d < 0) ? -d : d) * longint'(pwm_max) / longint'(vlink_ref);
      ff = (d < 0) ? -m : m;
    end
    tot = pi + ff;
    if (tot < 0) np = 0;
    else if (tot > longint'(pwm_max)) np = longint'(pwm_max);
    else np = tot;
  endtask

  // mode 0: plain; 1: perturb sampled inputs after start (R11); 2: extra start while busy (R10)
  task automatic run_update(string req, int mode);
    longint np, ni;
    model(np, ni);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= LAT + 3; k++) begin
      if (k > 1) @(negedge clk);
      chk((k == LAT) ? req : "R9", longint'(done), (k == LAT) ? 1 : 0);
      chk((k >= LAT) ? req : "R9", longint'(pwm), (k >= LAT) ? np : pwm_m);
      if (k == 1 && mode == 1) begin
        adc_raw = ~adc_raw; v_loop = v_loop ^ 16'h5a5a; sine_ph = 15'd123;
        vin_mag = vin_mag + 16'd7000; vlink_ref = 16'd3; i_ofs = -i_ofs - 16'sd99;
      end
      if (mode == 2 && k == 10) start = 1'b1;
      if (mode == 2 && k == 11) start = 1'b0;
    end
    pwm_m   = np;
    integ_m = ni;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    v_loop = 16'd20000; sine_ph = 15'd16384; vin_mag = 16'd300; adc_raw = 12'd2048;
    i_ofs = 16'sd0; kp = 16'd2000; ki = 16'd100;
    integ_lo = -40'sd1073741824; integ_hi = 40'sd1073741824;
    vlink_ref = 16'd1000; pwm_max = 16'd1000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", longint'(pwm), 0);
    chk("R1", longint'(done), 0);
    rst_n = 1'b1;

    // R2 R3 R6 R7: nominal and varied phase / sense patterns
    run_update("R2", 0);
    sine_ph = 15'd8192; adc_raw = 12'd2500;
    run_update("R6", 0);
    sine_ph = 15'd0; adc_raw = 12'd4000; i_ofs = -16'sd300;
    run_update("R3", 0);
    sine_ph = 15'd12000; adc_raw = 12'd3900; i_ofs = 16'sd250; v_loop = 16'd60000; vin_mag = 16'd1000;
    run_update("R2", 0);

    // R4: integrator builds over successive updates
    kp = 16'd10; ki = 16'd3000; adc_raw = 12'd4095; i_ofs = 16'sd0;
    v_loop = 16'd40000; sine_ph = 15'd16384; vin_mag = 16'd200;
    for (int i = 0; i < 4; i++) run_update("R4", 0);

    // R5: clamp at upper then lower limit
    integ_hi = 40'sd50000000; integ_lo = -40'sd20000000; ki = 16'd65535;
    run_update("R5", 0);
    run_update("R5", 0);
    adc_raw = 12'd0;
    run_update("R5", 0);
    run_update("R5", 0);

    // R8: result clamped low, then high
    kp = 16'd2000; ki = 16'd10;
    run_update("R8", 0);
    adc_raw = 12'd4095; v_loop = 16'd65535; vin_mag = 16'd10; vlink_ref = 16'd50000; pwm_max = 16'd800;
    integ_hi = 40'sd1000000000;
    run_update("R8", 0);
    run_update("R8", 0);

    // R7: negative feed-forward and zero link target
    integ_lo = -40'sd1000000000; kp = 16'd5; ki = 16'd1;
    adc_raw = 12'd3800; v_loop = 16'd30000; vin_mag = 16'd65535; vlink_ref = 16'd500; pwm_max = 16'd4000;
    run_update("R7", 0);
    vin_mag = 16'd640; vlink_ref = 16'd0;
    run_update("R7", 0);
    vlink_ref = 16'd9;
    run_update("R7", 0);

    // R11: inputs changed mid-update
    vin_mag = 16'd900; vlink_ref = 16'd2000; adc_raw = 12'd3000; i_ofs = 16'sd40; sine_ph = 15'd9000;
    run_update("R11", 1);
    // R10: start while busy
    adc_raw = 12'd3300; sine_ph = 15'd15000; v_loop = 16'd25000;
    run_update("R10", 2);
    run_update("R10", 0);

    // R1: reset mid-run clears output and integrator
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", longint'(pwm), 0);
    chk("R1", longint'(done), 0);
    rst_n = 1'b1;
    integ_m = 0; pwm_m = 0;
    ki = 16'd4000;
    run_update("R1", 0);
    run_update("R4", 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule